// File: doc/BRIEF.md
# Selectable-Source Clock Divider

This block derives one peripheral clock from a choice of three free-running input clocks: an on-chip RC oscillator, the main system clock and a low-power oscillator. Software configures it through three word registers on a simple memory-mapped bus: a source-choice register, an update-strobe register and a divide-ratio register. The selected source goes through an integer divider. A ratio of zero parks the output low.

A value written to the source-choice register is only a staged request. The active source changes only when the stored update bit goes from 0 to 1. Software therefore writes 0 and then 1 to the strobe, so a half-finished configuration never reaches the mux.

All logic runs on one fast system clock. Each source is brought in through a synchronizer and oversampled. The divider counts rising edges of the sampled source, and the output is a register in the system clock domain. Each source must therefore toggle no faster than every two system clock cycles.

Top module: `clk_src_div`

## Requirements
- R1: After reset, all three registers read zero and `clk_out` is low.
- R2: The source-choice register sits at byte offset 0x0. Bits [1:0] hold the code: 0 is the RC oscillator, 1 is the main clock, 2 is the low-power oscillator and 3 is reserved. Bits above 1 read zero, and writes to them are ignored.
- R3: Writing the source-choice register alone never changes the active source.
- R4: The update strobe is bit 0 of the register at offset 0x4. The staged code is copied to the active source only when a write moves the stored bit from 0 to 1. Writing 1 while the bit is already 1 has no effect. Bits above 0 read zero.
- R5: The divide ratio is bits [7:0] of the register at offset 0x8. While the active ratio is 0, `clk_out` stays low.
- R6: For a ratio N from 2 to 255, the `clk_out` period is N source periods. The output is high for floor(N/2) source periods and starts high at each period boundary.
- R7: For ratio 1, `clk_out` follows the selected source, SYNC_STAGES+1 system clock cycles later.
- R8: A new ratio is taken up only at the source rising edge that ends the current output period. Leaving ratio 0 starts a fresh period, high first, at the next source rising edge.
- R9: While the reserved code 3 is active, `clk_out` is low. When a valid source becomes active again, a fresh period starts at its next rising edge.
- R10: Reads at any other offset return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| src_irc | input | 1 | RC oscillator clock (code 0) |
| src_main | input | 1 | Main clock (code 1) |
| src_lpo | input | 1 | Low-power oscillator clock (code 2) |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench uses the defaults: 8-bit ratio, 32-bit data, 4-bit address and two synchronizer stages. With the full 8-bit ratio, the bench can cover ratio 255 and measure its 1020-cycle period. The three sources run at periods of 6, 4 and 10 system cycles. Because the periods differ, a switch of source shows up directly as a change in the measured `clk_out` period, for each of the update-strobe orderings.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int SEL_W = 2;
  localparam int N_SRC = 3;
  typedef enum logic [SEL_W-1:0] {
    SRC_RC   = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_LP   = 2'd2,
    SRC_NONE = 2'd3
  } src_code_e;
  localparam int OFF_SEL = 0;
  localparam int OFF_UPD = 4;
  localparam int OFF_DIV = 8;
endpackage

// File: rtl/csd_regs.sv
module csd_regs
  import csd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SEL_W-1:0]  act_sel,
  output logic              upd_q,
  output logic [DIV_W-1:0]  div_q
);
  logic              wr;
  logic              hit_sel, hit_upd, hit_div;
  logic [SEL_W-1:0]  sel_q, sel_n, act_n;
  logic              upd_n;
  logic [DIV_W-1:0]  div_n;
  logic              unused_wd;

  assign unused_wd = ^bus_wdata[DATA_W-1:DIV_W];
  assign wr      = bus_en & bus_we;
  assign hit_sel = (bus_addr == ADDR_W'(OFF_SEL));
  assign hit_upd = (bus_addr == ADDR_W'(OFF_UPD));
  assign hit_div = (bus_addr == ADDR_W'(OFF_DIV));

  // next-state
  always_comb begin
    sel_n = sel_q;
    upd_n = upd_q;
    div_n = div_q;
    act_n = act_sel;
    if (wr && hit_sel) sel_n = bus_wdata[SEL_W-1:0];
    if (wr && hit_div) div_n = bus_wdata[DIV_W-1:0];
    if (wr && hit_upd) begin
      upd_n = bus_wdata[0];
      if (bus_wdata[0] && !upd_q) act_n = sel_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      upd_q   <= 1'b0;
      div_q   <= '0;
      act_sel <= '0;
    end else begin
      sel_q   <= sel_n;
      upd_q   <= upd_n;
      div_q   <= div_n;
      act_sel <= act_n;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_sel)      bus_rdata = DATA_W'(sel_q);
    else if (hit_upd) bus_rdata = DATA_W'(upd_q);
    else if (hit_div) bus_rdata = DATA_W'(div_q);
  end
endmodule

// File: rtl/csd_srcmux.sv
module csd_srcmux
  import csd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [SEL_W-1:0] act_sel,
  output logic             src_s,
  output logic             src_ok
);
  localparam int PAD_W = 2 ** SEL_W;

  logic [N_SRC-1:0] sync_q [SYNC_STAGES];
  logic [PAD_W-1:0] padded;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= '0;
          else        sync_q[g] <= src_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= '0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign padded = PAD_W'(sync_q[SYNC_STAGES-1]);
  assign src_ok = (int'(act_sel) < N_SRC);
  assign src_s  = src_ok & padded[act_sel];
endmodule

// File: rtl/csd_div.sv
module csd_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_s,
  input  logic             src_ok,
  input  logic [DIV_W-1:0] div_cfg,
  output logic [DIV_W-1:0] act_div,
  output logic             clk_out
);
  logic             s_d;
  logic             rise, bound;
  logic [DIV_W-1:0] cnt_q, cnt_n, act_n;
  logic             out_n;

  assign rise  = src_s & ~s_d;
  assign bound = (act_div <= DIV_W'(1)) || (cnt_q == act_div - 1'b1);

  // next-state
  always_comb begin
    act_n = act_div;
    cnt_n = cnt_q;
    if (!src_ok) begin
      act_n = '0;
      cnt_n = '0;
    end else if (rise && bound) begin
      act_n = div_cfg;
      cnt_n = '0;
    end else if (rise) begin
      cnt_n = cnt_q + 1'b1;
    end
    if (!src_ok || act_n == '0)  out_n = 1'b0;
    else if (act_n == DIV_W'(1)) out_n = src_s;
    else                         out_n = (cnt_n < (act_n >> 1));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_d     <= 1'b0;
      cnt_q   <= '0;
      act_div <= '0;
      clk_out <= 1'b0;
    end else begin
      s_d     <= src_s;
      cnt_q   <= cnt_n;
      act_div <= act_n;
      clk_out <= out_n;
    end
  end
endmodule

// File: rtl/clk_src_div.sv
module clk_src_div
  import csd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              src_irc,
  input  logic              src_main,
  input  logic              src_lpo,
  output logic              clk_out
);
  logic [SEL_W-1:0] act_sel;
  logic             upd_q;
  logic [DIV_W-1:0] div_q, act_div;
  logic             src_s, src_ok;

  csd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .act_sel(act_sel), .upd_q(upd_q), .div_q(div_q)
  );

  csd_srcmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk(clk), .rst_n(rst_n), .src_in({src_lpo, src_main, src_irc}),
    .act_sel(act_sel), .src_s(src_s), .src_ok(src_ok)
  );

  csd_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .src_s(src_s), .src_ok(src_ok),
    .div_cfg(div_q), .act_div(act_div), .clk_out(clk_out)
  );
endmodule

// File: rtl/csd_chk.sv
module csd_chk
  import csd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              clk_out,
  input logic [SEL_W-1:0]  act_sel,
  input logic              upd_q,
  input logic [DIV_W-1:0]  act_div,
  input logic              src_s
);
  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == ADDR_W'(OFF_SEL)) |=> $stable(act_sel));
  // R4
  upd_noretrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == ADDR_W'(OFF_UPD) && upd_q) |=> $stable(act_sel));
  // R5
  div_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div == '0) |-> !clk_out);
  // R9
  rsv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel == SRC_NONE) |=> !clk_out);
  // R6
  out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(src_s));
  // R2
  sel_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_SEL)) |-> (bus_rdata[DATA_W-1:SEL_W] == '0));
  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(OFF_SEL) && bus_addr != ADDR_W'(OFF_UPD) &&
     bus_addr != ADDR_W'(OFF_DIV)) |-> (bus_rdata == '0));
endmodule

bind clk_src_div csd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .clk_out(clk_out),
  .act_sel(act_sel), .upd_q(upd_q), .act_div(act_div), .src_s(src_s)
);

// File: tb/clk_src_div_tb.sv
`timescale 1ns/1ps
module clk_src_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        src_irc = 1'b0, src_main = 1'b0, src_lpo = 1'b0;
  logic        clk_out;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  clk_src_div u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_irc(src_irc), .src_main(src_main), .src_lpo(src_lpo), .clk_out(clk_out)
  );

  // sources: periods 6, 4, 10 system cycles, changed away from the active edge
  int c_irc = 0, c_main = 0, c_lpo = 0;
  always @(negedge clk) begin
    c_irc++;  if (c_irc  == 3) begin c_irc  = 0; src_irc  = ~src_irc;  end
    c_main++; if (c_main == 2) begin c_main = 0; src_main = ~src_main; end
    c_lpo++;  if (c_lpo  == 5) begin c_lpo  = 0; src_lpo  = ~src_lpo;  end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: behavioural, updated at each active edge
  int m_sel, m_upd, m_div, m_asel, m_act, m_cnt;
  bit m_out, m_sd;
  bit [2:0] m_s0, m_s1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_upd = 0; m_div = 0; m_asel = 0; m_act = 0; m_cnt = 0;
      m_out = 0; m_sd = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      bit s, rise, ok;
      int na, nc;
      ok   = (m_asel != 3);
      s    = ok ? m_s1[m_asel] : 1'b0;
      rise = s && !m_sd;
      na = m_act; nc = m_cnt;
      if (!ok) begin na = 0; nc = 0; end
      else if (rise) begin
        if (m_act <= 1 || m_cnt == m_act - 1) begin na = m_div; nc = 0; end
        else nc = m_cnt + 1;
      end
      m_out = (!ok || na == 0) ? 1'b0 : (na == 1) ? s : (nc < na / 2);
      m_sd = s; m_act = na; m_cnt = nc;
      m_s1 = m_s0; m_s0 = {src_lpo, src_main, src_irc};
      if (bus_en && bus_we) begin
        case (bus_addr)
          4'h0: m_sel = bus_wdata[1:0];
          4'h4: begin
            if (bus_wdata[0] && m_upd == 0) m_asel = m_sel;
            m_upd = bus_wdata[0];
          end
          4'h8: m_div = bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model (R6, R7, R8 timing)
  always @(negedge clk) begin
    if (rst_n) chk(clk_out == m_out, "R8 model", clk_out, m_out);
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a[3:0]; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input int a, input int exp, input string req);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a[3:0];
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic wait_rise();
    bit prev;
    prev = clk_out;
    @(negedge clk);
    while (!(prev == 0 && clk_out == 1)) begin
      prev = clk_out;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int ep, input int eh, input string req);
    int p, h;
    bit prev;
    wait_rise();
    p = 1; h = 1; prev = 1;
    forever begin
      @(negedge clk);
      if (prev == 0 && clk_out == 1) break;
      p++;
      if (clk_out) h++;
      prev = clk_out;
    end
    chk(p == ep, {req, " period"}, p, ep);
    chk(h == eh, {req, " high"}, h, eh);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic update();
    bus_wr(4, 0);
    bus_wr(4, 1);
  endtask

  initial begin
    idle(5);
    rst_n = 1;
    // R1: reset state
    bus_rd(0, 0, "R1 sel");
    bus_rd(4, 0, "R1 upd");
    bus_rd(8, 0, "R1 div");
    idle(40);
    chk(clk_out == 0, "R1 out", clk_out, 0);

    // R7: ratio 1 on the RC source (period 6)
    bus_wr(8, 1);
    wait_rise();
    measure(6, 3, "R7 irc");

    // R3: staged selection alone does nothing
    bus_wr(0, 1);
    idle(30);
    measure(6, 3, "R3 no switch");

    // R4: 0 then 1 switches to main (period 4)
    update();
    wait_rise();
    measure(4, 2, "R4 switch main");

    // R4: writing 1 while already 1 does not retrigger
    bus_wr(0, 2);
    bus_wr(4, 1);
    idle(30);
    measure(4, 2, "R4 no retrigger");
    bus_wr(4, 32'hFFFF_FFFE);
    bus_rd(4, 0, "R4 upd bit0 only");
    bus_wr(4, 32'hFFFF_FFFF);
    bus_rd(4, 1, "R4 upd readback");
    wait_rise();
    measure(10, 5, "R4 switch lpo");

    // R2: reserved select bits
    bus_wr(0, 32'hFFFF_FFFD);
    bus_rd(0, 1, "R2 sel mask");
    update();
    wait_rise();

    // R6: ratios on the main source
    bus_wr(8, 3);
    wait_rise();
    measure(12, 4, "R6 div3");
    bus_wr(8, 2);
    wait_rise();
    measure(8, 4, "R6 div2");
    bus_wr(8, 5);
    wait_rise();
    measure(20, 8, "R6 div5");
    bus_wr(8, 255);
    wait_rise();
    measure(1020, 508, "R6 div255");
    bus_rd(8, 255, "R5 div readback");

    // R8: mid-period change; model checks the boundary, then new period
    bus_wr(8, 5);
    wait_rise();
    measure(20, 8, "R8 div5");
    idle(3);
    bus_wr(8, 2);
    wait_rise();
    measure(8, 4, "R8 new ratio");

    // R5: ratio 0 parks output low
    bus_wr(8, 0);
    idle(20);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clk_out) begin chk(0, "R5 off", 1, 0); break; end
    end
    chk(clk_out == 0, "R5 off", clk_out, 0);
    bus_wr(8, 4);
    measure(16, 8, "R8 restart");

    // R9: reserved code active
    bus_wr(0, 3);
    update();
    idle(8);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clk_out) begin chk(0, "R9 low", 1, 0); break; end
    end
    chk(clk_out == 0, "R9 low", clk_out, 0);
    bus_wr(0, 0);
    update();
    measure(24, 12, "R9 restart irc");

    // R10: unmapped offsets
    bus_wr(12, 32'hA5A5_A5A5);
    bus_rd(12, 0, "R10 unmapped");
    bus_rd(2, 0, "R10 unaligned");
    bus_rd(0, 0, "R10 sel intact");
    bus_rd(8, 4, "R10 div intact");

    idle(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule